// File: doc/BRIEF.md
# ECC Decode Interrupt Status Unit

This unit sits beside an error-correction decoder and turns its per-sector completion pulses into a single level interrupt for software. The decoder signals each finished sector with a one-cycle pulse and the sector's index. Every pulse records a bit in a completion mask and raises a sticky status flag. The interrupt line is the status flag gated by the interrupt enable.

Software reaches the unit over a small word-wide register bus. A read of the status register returns the flag and clears it as a side effect. That clear only takes effect while the interrupt enable is set. The completion mask can be read freely, with no side effect, and compared against the expected set of sectors.

A control register starts a decode run, which clears the mask and the flag and loads an outstanding-sector counter from the programmed count. The control register can also stop the run. The design is built so that the races between a status read and a late sector pulse behave the same way every time.

Top module: `ecc_dec_irq_unit`

## Requirements
- R1: After a synchronous active-high reset, the enable, count, completion mask, status and run flag are all zero. The interrupt is low. A control read returns 2, because the idle flag is high and the run flag is low. Addresses 5 to 7 read as zero.
- R2: While a run is active, a sector pulse with index k (0 to NSEC-1) sets bit k of the completion mask (address 3) and sets status bit 0 (address 4). Each pulse of a multi-sector page is an event of its own.
- R3: A status read while the enable is nonzero returns 1 when the flag is set and clears the flag at that clock edge. From the same edge the interrupt is low.
- R4: A status read while the enable is zero returns the flag and leaves it set.
- R5: A sector pulse that arrives after a clearing status read sets the flag again, and the interrupt returns high at that edge.
- R6: When a sector pulse and a status read fall in the same cycle, the flag is set after that edge.
- R7: A read of the completion mask changes neither the mask nor the flag.
- R8: Address 0 is the enable. Writing zero to it holds the interrupt low while the flag stays set, and writing a nonzero value restores the interrupt.
- R9: Writing 2 to the control register (address 1) clears the run flag (control read bit 0). Sector pulses that arrive while stopped change neither the mask nor the flag.
- R10: Writing 1 to the control register clears the mask and the flag, sets the run flag, and loads the outstanding counter from the count register (address 2). Control read bit 1 (idle) is low until that many sectors have completed.
- R11: After every clock edge, the interrupt equals the status flag ANDed with the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_rd | input | 1 | Read strobe; side effects take place at the clock edge |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from the address |
| sec_done | input | 1 | One-cycle sector completion pulse from the decoder |
| sec_idx | input | IDX_W | Index of the completed sector |
| irq | output | 1 | Level decode interrupt |

## Verification
Two functions can fall in the same cycle: the clearing side effect of a status read and a sector completion pulse that sets the same flag. The bench drives both strobes in one cycle. It then reads the status again, and a value of 1 shows that the late event survived. It also stages the near-miss case, where the pulse comes one cycle after the clearing read, and checks that the interrupt comes back. Every bus read is compared with a requirement-derived model, and the interrupt level is checked after every edge.

// File: rtl/ecc_dec_irq_pkg.sv
package ecc_dec_irq_pkg;
   // register addresses
   localparam int unsigned ADR_IEN  = 0;
   localparam int unsigned ADR_CTRL = 1;
   localparam int unsigned ADR_SCNT = 2;
   localparam int unsigned ADR_DONE = 3;
   localparam int unsigned ADR_STS  = 4;
   // control write codes
   localparam int unsigned CODE_START = 1;
   localparam int unsigned CODE_STOP  = 2;
endpackage

// File: rtl/eds_done_track.sv
module eds_done_track #(
   parameter int unsigned NSEC  = 16,
   parameter int unsigned IDX_W = 4,
   parameter int unsigned CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic             stop,
   input  logic             sec_done,
   input  logic [IDX_W-1:0] sec_idx,
   input  logic [CNT_W-1:0] cnt_load,
   output logic             ev_ok,
   output logic             running,
   output logic             idle,
   output logic [NSEC-1:0]  done_mask
);
   logic             run_q;
   logic [CNT_W-1:0] rem_q;

   assign ev_ok   = sec_done && run_q && !start;
   assign running = run_q;
   assign idle    = (rem_q == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         run_q <= 1'b0;
         rem_q <= '0;
      end else if (start) begin
         run_q <= 1'b1;
         rem_q <= cnt_load;
      end else begin
         if (stop) run_q <= 1'b0;
         if (ev_ok && rem_q != '0) rem_q <= rem_q - 1'b1;
      end
   end

   for (genvar i = 0; i < NSEC; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (rst || start)
            done_mask[i] <= 1'b0;
         else if (ev_ok && sec_idx == IDX_W'(i))
            done_mask[i] <= 1'b1;
      end
   end
endmodule

// File: rtl/eds_irq_status.sv
module eds_irq_status #(
   parameter bit IRQ_REG = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic clr_all,
   input  logic set_ev,
   input  logic rd_sts,
   input  logic wr_ien,
   input  logic ien_val,
   output logic sts,
   output logic ien,
   output logic irq
);
   logic sts_q, sts_nxt;
   logic ien_q, ien_nxt;

   always_comb begin
      ien_nxt = wr_ien ? ien_val : ien_q;
      if (clr_all)                sts_nxt = 1'b0;
      else if (set_ev)            sts_nxt = 1'b1;
      else if (rd_sts && ien_q)   sts_nxt = 1'b0;
      else                        sts_nxt = sts_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sts_q <= 1'b0;
         ien_q <= 1'b0;
      end else begin
         sts_q <= sts_nxt;
         ien_q <= ien_nxt;
      end
   end

   assign sts = sts_q;
   assign ien = ien_q;

   if (IRQ_REG) begin : g_irq_ff
      logic irq_q;
      always_ff @(posedge clk) begin
         if (rst) irq_q <= 1'b0;
         else     irq_q <= sts_nxt & ien_nxt;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = sts_q & ien_q;
   end
endmodule

// File: rtl/ecc_dec_irq_unit.sv
module ecc_dec_irq_unit
   import ecc_dec_irq_pkg::*;
#(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned ADDR_W  = 3,
   parameter int unsigned NSEC    = 16,
   parameter int unsigned IDX_W   = 4,
   parameter bit          IRQ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              sec_done,
   input  logic [IDX_W-1:0]  sec_idx,
   output logic              irq
);
   localparam int unsigned CNT_W = $clog2(NSEC + 1);

   if (NSEC < 1 || NSEC > DATA_W) begin : g_bad_nsec
      $error("NSEC must lie in 1..DATA_W");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("ADDR_W must be at least 3");
   end
   if (IDX_W < 1 || (1 << IDX_W) < NSEC) begin : g_bad_idx
      $error("IDX_W too narrow for NSEC");
   end

   logic sel_ien, sel_ctrl, sel_scnt, sel_done, sel_sts;
   logic start_w, stop_w;
   logic ev_ok, running, idle, sts, ien;
   logic [NSEC-1:0]  done_mask;
   logic [CNT_W-1:0] cnt_q;

   assign sel_ien  = (bus_addr == ADDR_W'(ADR_IEN));
   assign sel_ctrl = (bus_addr == ADDR_W'(ADR_CTRL));
   assign sel_scnt = (bus_addr == ADDR_W'(ADR_SCNT));
   assign sel_done = (bus_addr == ADDR_W'(ADR_DONE));
   assign sel_sts  = (bus_addr == ADDR_W'(ADR_STS));

   assign start_w = bus_wr && sel_ctrl && (bus_wdata == DATA_W'(CODE_START));
   assign stop_w  = bus_wr && sel_ctrl && (bus_wdata == DATA_W'(CODE_STOP));

   always_ff @(posedge clk) begin
      if (rst)                  cnt_q <= '0;
      else if (bus_wr && sel_scnt) cnt_q <= bus_wdata[CNT_W-1:0];
   end

   eds_done_track #(
      .NSEC (NSEC),
      .IDX_W(IDX_W),
      .CNT_W(CNT_W)
   ) u_track (
      .clk      (clk),
      .rst      (rst),
      .start    (start_w),
      .stop     (stop_w),
      .sec_done (sec_done),
      .sec_idx  (sec_idx),
      .cnt_load (cnt_q),
      .ev_ok    (ev_ok),
      .running  (running),
      .idle     (idle),
      .done_mask(done_mask)
   );

   eds_irq_status #(
      .IRQ_REG(IRQ_REG)
   ) u_sts (
      .clk    (clk),
      .rst    (rst),
      .clr_all(start_w),
      .set_ev (ev_ok),
      .rd_sts (bus_rd && sel_sts),
      .wr_ien (bus_wr && sel_ien),
      .ien_val(|bus_wdata),
      .sts    (sts),
      .ien    (ien),
      .irq    (irq)
   );

   always_comb begin
      bus_rdata = '0;
      if (sel_ien)       bus_rdata = DATA_W'(ien);
      else if (sel_ctrl) bus_rdata = DATA_W'({idle, running});
      else if (sel_scnt) bus_rdata = DATA_W'(cnt_q);
      else if (sel_done) bus_rdata = DATA_W'(done_mask);
      else if (sel_sts)  bus_rdata = DATA_W'(sts);
   end
endmodule

// File: rtl/ecc_dec_irq_chk.sv
module ecc_dec_irq_chk
   import ecc_dec_irq_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned NSEC   = 16
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              sec_done,
   input logic              irq,
   input logic              sts,
   input logic              ien,
   input logic              running,
   input logic [NSEC-1:0]   done_mask
);
   logic a_sts, a_done, a_start, a_stop, a_ev;
   assign a_sts   = bus_rd && bus_addr == ADDR_W'(ADR_STS);
   assign a_done  = bus_rd && bus_addr == ADDR_W'(ADR_DONE);
   assign a_start = bus_wr && bus_addr == ADDR_W'(ADR_CTRL) && bus_wdata == DATA_W'(CODE_START);
   assign a_stop  = bus_wr && bus_addr == ADDR_W'(ADR_CTRL) && bus_wdata == DATA_W'(CODE_STOP);
   assign a_ev    = sec_done && running && !a_start;

   p_event_sets_r2: assert property (@(posedge clk) disable iff (rst)
      a_ev |=> sts);
   p_read_clears_r3: assert property (@(posedge clk) disable iff (rst)
      (a_sts && ien && !a_ev && !a_start) |=> !sts);
   p_masked_hold_r4: assert property (@(posedge clk) disable iff (rst)
      (a_sts && !ien && sts && !a_start) |=> sts);
   p_collide_keep_r6: assert property (@(posedge clk) disable iff (rst)
      (a_sts && a_ev) |=> sts);
   p_done_read_r7: assert property (@(posedge clk) disable iff (rst)
      (a_done && !a_ev && !a_start) |=> $stable(done_mask));
   p_stop_r9: assert property (@(posedge clk) disable iff (rst)
      (a_stop && !a_start) |=> !running);
   p_stopped_ignore_r9: assert property (@(posedge clk) disable iff (rst)
      (!running && !a_start) |=> $stable(done_mask));
   p_start_clear_r10: assert property (@(posedge clk) disable iff (rst)
      a_start |=> (done_mask == '0 && !sts && running));
   p_irq_level_r11: assert property (@(posedge clk) disable iff (rst)
      (sts && ien) |-> irq);
   p_irq_quiet_r11: assert property (@(posedge clk) disable iff (rst)
      !(sts && ien) |-> !irq);
endmodule

bind ecc_dec_irq_unit ecc_dec_irq_chk #(
   .DATA_W(DATA_W),
   .ADDR_W(ADDR_W),
   .NSEC  (NSEC)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .bus_addr (bus_addr),
   .bus_rd   (bus_rd),
   .bus_wr   (bus_wr),
   .bus_wdata(bus_wdata),
   .sec_done (sec_done),
   .irq      (irq),
   .sts      (sts),
   .ien      (ien),
   .running  (running),
   .done_mask(done_mask)
);

// File: tb/tb_ecc_dec_irq_unit.sv
module tb_ecc_dec_irq_unit;
   localparam int DW = 16;
   localparam int AW = 3;
   localparam int NS = 16;
   localparam int IW = 4;

   logic          clk = 1'b0;
   logic          rst;
   logic [AW-1:0] bus_addr;
   logic          bus_rd, bus_wr;
   logic [DW-1:0] bus_wdata, bus_rdata;
   logic          sec_done;
   logic [IW-1:0] sec_idx;
   logic          irq;

   always #5 clk = ~clk;

   ecc_dec_irq_unit #(.DATA_W(DW), .ADDR_W(AW), .NSEC(NS), .IDX_W(IW)) dut (
      .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sec_done(sec_done),
      .sec_idx(sec_idx), .irq(irq)
   );

   int vec = 0;
   int bad = 0;
   logic [DW-1:0] last_rd;

   // requirement model
   bit            m_sts, m_ien, m_run;
   logic [DW-1:0] m_done;
   int            m_rem, m_cnt;

   task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
      vec++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] exp_rd(int a);
      case (a)
         0: return DW'(m_ien);
         1: return DW'({(m_rem == 0), m_run});
         2: return DW'(m_cnt);
         3: return m_done;
         4: return DW'(m_sts);
         default: return '0;
      endcase
   endfunction

   // one bus cycle; entered and left at a falling edge
   task automatic cyc(string tag, bit rd, bit wr, int a, int wd, bit sd, int idx);
      bit st, sp, ev;
      bus_rd = rd; bus_wr = wr; bus_addr = a[AW-1:0];
      bus_wdata = wd[DW-1:0]; sec_done = sd; sec_idx = idx[IW-1:0];
      #1;
      last_rd = bus_rdata;
      if (rd) chk(tag, bus_rdata, exp_rd(a));
      st = wr && a == 1 && wd == 1;
      sp = wr && a == 1 && wd == 2;
      ev = sd && m_run && !st;
      if (st) begin
         m_done = '0; m_sts = 0; m_run = 1; m_rem = m_cnt;
      end else begin
         if (ev) begin
            m_done[idx] = 1'b1; m_sts = 1;
            if (m_rem > 0) m_rem--;
         end else if (rd && a == 4 && m_ien) m_sts = 0;
         if (sp) m_run = 0;
      end
      if (wr && a == 0) m_ien = (wd != 0);
      if (wr && a == 2) m_cnt = wd % 32;
      @(negedge clk);
      bus_rd = 0; bus_wr = 0; sec_done = 0;
      chk({tag, " irq level R11"}, DW'(irq), DW'(m_sts & m_ien));
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   endtask

   initial begin
      #1_000_000;
      bad++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      rst = 1; bus_rd = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
      sec_done = 0; sec_idx = '0;
      m_sts = 0; m_ien = 0; m_run = 0; m_done = '0; m_rem = 0; m_cnt = 0;
      repeat (3) @(negedge clk);
      rst = 0;
      chk("R1 irq after reset", DW'(irq), '0);
      for (int a = 0; a < 8; a++) cyc("R1 reset readback", 1, 0, a, 0, 0, 0);
      cyc("R1 ctrl idle", 1, 0, 1, 0, 0, 0);
      chk("R1 ctrl value", last_rd, 16'd2);

      // sweep every page size, sectors finishing in reverse order
      for (int n = 1; n <= NS; n++) begin
         cyc("R10 count", 0, 1, 2, n, 0, 0);
         cyc("R8 enable", 0, 1, 0, 1, 0, 0);
         cyc("R10 start", 0, 1, 1, 1, 0, 0);
         cyc("R10 busy", 1, 0, 1, 0, 0, 0);
         chk("R10 busy value", last_rd, 16'd1);
         for (int i = 0; i < n; i++) begin
            cyc("R2 sector", 0, 0, 0, 0, 1, n - 1 - i);
            chk("R2 irq raised", DW'(irq), 16'd1);
            cyc("R3 status read", 1, 0, 4, 0, 0, 0);
            chk("R3 read value", last_rd, 16'd1);
            chk("R3 irq dropped", DW'(irq), 16'd0);
         end
         cyc("R7 mask read", 1, 0, 3, 0, 0, 0);
         chk("R2 mask", last_rd, DW'((32'h1 << n) - 1));
         cyc("R7 mask reread", 1, 0, 3, 0, 0, 0);
         chk("R7 mask unchanged", last_rd, DW'((32'h1 << n) - 1));
         cyc("R10 done", 1, 0, 1, 0, 0, 0);
         chk("R10 idle value", last_rd, 16'd3);
         cyc("R9 stop", 0, 1, 1, 2, 0, 0);
      end

      // masked status does not clear
      cyc("R10 count", 0, 1, 2, 2, 0, 0);
      cyc("R10 start", 0, 1, 1, 1, 0, 0);
      cyc("R8 mask", 0, 1, 0, 0, 0, 0);
      cyc("R2 sector", 0, 0, 0, 0, 1, 0);
      chk("R8 irq masked", DW'(irq), 16'd0);
      cyc("R4 read", 1, 0, 4, 0, 0, 0);
      cyc("R4 reread", 1, 0, 4, 0, 0, 0);
      chk("R4 still set", last_rd, 16'd1);
      cyc("R8 unmask", 0, 1, 0, 16'h0100, 0, 0);
      chk("R8 irq restored", DW'(irq), 16'd1);
      cyc("R8 mask again", 0, 1, 0, 0, 0, 0);
      chk("R8 irq low", DW'(irq), 16'd0);
      cyc("R8 status kept", 1, 0, 4, 0, 0, 0);
      chk("R8 status kept value", last_rd, 16'd1);

      // collision: read and sector in the same cycle
      cyc("R8 enable", 0, 1, 0, 1, 0, 0);
      cyc("R6 collide", 1, 0, 4, 0, 1, 1);
      cyc("R6 after", 1, 0, 4, 0, 0, 0);
      chk("R6 kept set", last_rd, 16'd1);
      cyc("R3 cleared", 1, 0, 4, 0, 0, 0);
      chk("R3 cleared value", last_rd, 16'd0);

      // late sector after clearing read
      cyc("R10 count", 0, 1, 2, 3, 0, 0);
      cyc("R10 start", 0, 1, 1, 1, 0, 0);
      cyc("R2 sector", 0, 0, 0, 0, 1, 0);
      cyc("R5 read", 1, 0, 4, 0, 0, 0);
      chk("R5 irq dropped", DW'(irq), 16'd0);
      cyc("R5 late sector", 0, 0, 0, 0, 1, 1);
      chk("R5 irq reraised", DW'(irq), 16'd1);
      cyc("R5 status", 1, 0, 4, 0, 0, 0);
      chk("R5 status value", last_rd, 16'd1);

      // stopped: sectors ignored
      cyc("R9 stop", 0, 1, 1, 2, 0, 0);
      cyc("R9 ctrl", 1, 0, 1, 0, 0, 0);
      chk("R9 run low", last_rd & 16'd1, 16'd0);
      cyc("R9 ignored sector", 0, 0, 0, 0, 1, 5);
      cyc("R9 mask", 1, 0, 3, 0, 0, 0);
      chk("R9 mask unchanged", last_rd, 16'h0003);
      cyc("R9 status", 1, 0, 4, 0, 0, 0);
      chk("R9 status unchanged", last_rd, 16'd0);

      // start with zero count stays idle
      cyc("R10 zero count", 0, 1, 2, 0, 0, 0);
      cyc("R10 start", 0, 1, 1, 1, 0, 0);
      cyc("R10 ctrl", 1, 0, 1, 0, 0, 0);
      chk("R10 idle with zero count", last_rd, 16'd3);
      summary();
   end
endmodule